// File: doc/BRIEF.md
# Multichannel Spike Window Compressor

This block sits after a single shared 8-bit converter that scans 64 recording channels in a fixed round-robin order. It keeps separate state for every channel. That state is a short history of the channel's recent samples, a programmable threshold and a capture counter. When a channel's signal rises through its threshold, the block records a short waveform window around that event. Everything outside such windows is thrown away.

Each finished window becomes a tagged frame and waits in a small frame queue. A serializer drains the queue onto one output wire at a fixed, much lower bit rate. Every bit is Manchester coded. When no frame is waiting, the serializer fills the line with zero bytes, so the line always carries transitions. The half-bit rate comes from a clock-enable input, so the line rate is set outside the block.

Top module: `spike_compressor`

## Requirements
- R1: Samples are unsigned (offset-binary). A channel triggers when its previous accepted sample is less than or equal to its threshold and the current sample is strictly greater. A sample equal to the threshold does not trigger. Channel c's threshold is `thr_vec[8*c+7:8*c]`, and after reset every channel's previous sample counts as 0.
- R2: A triggered window holds 20 samples of that channel, oldest first: the 4 samples before the trigger, the trigger sample, and the next 15 samples.
- R3: A channel that is capturing ignores further threshold crossings until its 20th sample is stored. The first crossing after that starts a new window.
- R4: A frame is 22 bytes. Byte 0 is 0xA5, byte 1 is the channel number in bits 5:0 with bits 7:6 zero, and bytes 2 to 21 are the window samples. Each byte is sent most significant bit first.
- R5: A 1 bit is sent high then low and a 0 bit low then high. Each half lasts one cycle in which `half_tick` is high, and the line holds its value while `half_tick` is low.
- R6: Between frames, with nothing queued, the line carries 0x00 bytes. No other value appears outside a frame.
- R7: Completed frames queue in a FIFO of 8 frames, plus the frame being sent. A frame that completes while the FIFO is full is dropped, and `ovf_flag` rises and stays high until reset.
- R8: Synchronous reset clears every channel's history and capture state, empties the FIFO, clears `ovf_flag` and aborts any frame in flight. After reset the line starts a 0x00 byte, so its first half-bit is low.
- R9: Cycles with `smp_valid` low change no channel state and cannot trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 6 | Channel index of the sample |
| smp_data | input | 8 | Offset-binary sample |
| thr_vec | input | 512 | Per-channel thresholds, channel c in bits 8c+7:8c |
| half_tick | input | 1 | Clock enable, one half-bit per high cycle |
| ser_out | output | 1 | Manchester-coded serial line |
| ovf_flag | output | 1 | Sticky frame-drop flag |

## Verification
The assertions assume that the samples of any one channel are at least a few cycles apart. This holds in real use, because all 64 channels are scanned in order before any channel repeats. The bench always drives full rounds of channel 0 to 63 and inserts invalid cycles between them. The Manchester checks assume `half_tick` is a clean clock enable. The bench holds it high, so each clock cycle is one half-bit and its decoder can resynchronize on every reset release.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int SMP_W = 8;
  localparam logic [7:0] SYNC_BYTE = 8'hA5;
  localparam logic [7:0] IDLE_BYTE = 8'h00;

  // rising crossing of an unsigned threshold
  function automatic logic crossed(input logic [SMP_W-1:0] prev,
                                   input logic [SMP_W-1:0] cur,
                                   input logic [SMP_W-1:0] thr);
    return (prev <= thr) && (cur > thr);
  endfunction

  // first half carries the bit, second half its complement
  function automatic logic manch_half(input logic b, input logic second);
    return b ^ second;
  endfunction
endpackage

// File: rtl/spk_capture.sv
module spk_capture #(
  parameter int NCH = 64,
  parameter int PRE = 4,
  parameter int WIN = 20,
  parameter int CW  = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [CW-1:0]                 in_chan,
  input  logic [spk_pkg::SMP_W-1:0]     in_data,
  input  logic [NCH*spk_pkg::SMP_W-1:0] thr_vec,
  output logic                          trig_o,
  output logic                          done_o,
  output logic [CW-1:0]                 done_chan_o,
  output logic [WIN*spk_pkg::SMP_W-1:0] done_data_o
);
  localparam int SW   = spk_pkg::SMP_W;
  localparam int CNTW = $clog2(WIN + 1);

  logic [SW-1:0]   hist [NCH][PRE];
  logic [SW-1:0]   win  [NCH][WIN];
  logic            busy [NCH];
  logic [CNTW-1:0] cnt  [NCH];

  logic [SW-1:0]     cur_thr;
  logic              last;
  logic [WIN*SW-1:0] packed_win;

  assign cur_thr = thr_vec[in_chan*SW +: SW];
  assign trig_o  = in_valid && !busy[in_chan] &&
                   spk_pkg::crossed(hist[in_chan][0], in_data, cur_thr);
  assign last    = in_valid && busy[in_chan] && (cnt[in_chan] == CNTW'(WIN - 1));

  always_comb begin
    for (int i = 0; i < WIN - 1; i++) packed_win[i*SW +: SW] = win[in_chan][i];
    packed_win[(WIN-1)*SW +: SW] = in_data;
  end

  // history and capture control
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        busy[c] <= 1'b0;
        cnt[c]  <= '0;
        for (int p = 0; p < PRE; p++) hist[c][p] <= '0;
      end
    end else if (in_valid) begin
      hist[in_chan][0] <= in_data;
      for (int p = 1; p < PRE; p++) hist[in_chan][p] <= hist[in_chan][p-1];
      if (trig_o) begin
        busy[in_chan] <= 1'b1;
        cnt[in_chan]  <= CNTW'(PRE + 1);
      end else if (last) begin
        busy[in_chan] <= 1'b0;
        cnt[in_chan]  <= '0;
      end else if (busy[in_chan]) begin
        cnt[in_chan]  <= cnt[in_chan] + 1'b1;
      end
    end
  end

  // window storage needs no reset: it is always loaded before use
  always_ff @(posedge clk) begin
    if (trig_o) begin
      for (int i = 0; i < PRE; i++) win[in_chan][i] <= hist[in_chan][PRE-1-i];
      win[in_chan][PRE] <= in_data;
    end else if (in_valid && busy[in_chan]) begin
      win[in_chan][cnt[in_chan]] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_o <= 1'b0;
    else     done_o <= last;
    done_chan_o <= in_chan;
    done_data_o <= packed_win;
  end
endmodule

// File: rtl/spk_frame_fifo.sv
module spk_frame_fifo #(
  parameter int DW    = 166,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full)  wr_ptr <= bump(wr_ptr);
      if (pop && !empty)  rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spk_manch_tx.sv
module spk_manch_tx #(
  parameter int CW  = 6,
  parameter int WIN = 20
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              half_tick,
  input  logic                              fifo_empty,
  input  logic [CW+WIN*spk_pkg::SMP_W-1:0] fifo_head,
  output logic                              pop_o,
  output logic                              ser_o,
  output logic                              phase_o
);
  localparam int SW     = spk_pkg::SMP_W;
  localparam int FW     = CW + WIN * SW;
  localparam int NBYTES = WIN + 2;
  localparam int IW     = $clog2(NBYTES);

  logic [FW-1:0] tx_frame;
  logic          in_frame;
  logic [IW-1:0] fidx;
  logic [7:0]    cur_byte;
  logic [2:0]    bit_idx;
  logic          phase;
  logic          byte_end, more;

  function automatic logic [7:0] frame_byte(input logic [FW-1:0] f, input int idx);
    logic [7:0] b;
    b = '0;
    if (idx == 0)      b = spk_pkg::SYNC_BYTE;
    else if (idx == 1) b[CW-1:0] = f[FW-1 -: CW];
    else               b = f[(idx-2)*SW +: SW];
    return b;
  endfunction

  assign byte_end = half_tick && phase && (bit_idx == 3'd7);
  assign more     = in_frame && (fidx != IW'(NBYTES - 1));
  assign pop_o    = byte_end && !more && !fifo_empty;
  assign ser_o    = spk_pkg::manch_half(cur_byte[3'd7 - bit_idx], phase);
  assign phase_o  = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_frame <= '0;
      in_frame <= 1'b0;
      fidx     <= '0;
      cur_byte <= spk_pkg::IDLE_BYTE;
      bit_idx  <= '0;
      phase    <= 1'b0;
    end else if (half_tick) begin
      if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (bit_idx != 3'd7) begin
          bit_idx <= bit_idx + 1'b1;
        end else begin
          bit_idx <= '0;
          if (more) begin
            fidx     <= fidx + 1'b1;
            cur_byte <= frame_byte(tx_frame, int'(fidx) + 1);
          end else if (!fifo_empty) begin
            tx_frame <= fifo_head;
            in_frame <= 1'b1;
            fidx     <= '0;
            cur_byte <= spk_pkg::SYNC_BYTE;
          end else begin
            in_frame <= 1'b0;
            cur_byte <= spk_pkg::IDLE_BYTE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spike_compressor.sv
module spike_compressor #(
  parameter int NCH         = 64,
  parameter int PRE         = 4,
  parameter int POST        = 16,
  parameter int FIFO_FRAMES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          smp_valid,
  input  logic [$clog2(NCH)-1:0]        smp_chan,
  input  logic [spk_pkg::SMP_W-1:0]     smp_data,
  input  logic [NCH*spk_pkg::SMP_W-1:0] thr_vec,
  input  logic                          half_tick,
  output logic                          ser_out,
  output logic                          ovf_flag
);
  localparam int CW  = $clog2(NCH);
  localparam int WIN = PRE + POST;
  localparam int FW  = CW + WIN * spk_pkg::SMP_W;

  // named internal events, observed by the bound checker
  logic          trig_evt, done_evt, push_evt, drop_evt, pop_evt;
  logic          fifo_full, fifo_empty, tx_phase;
  logic [CW-1:0] done_chan;
  logic [WIN*spk_pkg::SMP_W-1:0] done_data;
  logic [FW-1:0] fifo_head;

  spk_capture #(.NCH(NCH), .PRE(PRE), .WIN(WIN), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_chan(smp_chan),
    .in_data(smp_data), .thr_vec(thr_vec), .trig_o(trig_evt),
    .done_o(done_evt), .done_chan_o(done_chan), .done_data_o(done_data)
  );

  assign push_evt = done_evt && !fifo_full;
  assign drop_evt = done_evt && fifo_full;

  spk_frame_fifo #(.DW(FW), .DEPTH(FIFO_FRAMES)) u_fifo (
    .clk(clk), .rst(rst), .push(push_evt), .din({done_chan, done_data}),
    .pop(pop_evt), .dout(fifo_head), .full(fifo_full), .empty(fifo_empty)
  );

  spk_manch_tx #(.CW(CW), .WIN(WIN)) u_tx (
    .clk(clk), .rst(rst), .half_tick(half_tick), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .pop_o(pop_evt), .ser_o(ser_out), .phase_o(tx_phase)
  );

  always_ff @(posedge clk) begin
    if (rst)           ovf_flag <= 1'b0;
    else if (drop_evt) ovf_flag <= 1'b1;
  end
endmodule

// File: rtl/spike_compressor_chk.sv
module spike_compressor_chk (
  input logic clk,
  input logic rst,
  input logic smp_valid,
  input logic half_tick,
  input logic ser_out,
  input logic ovf_flag,
  input logic trig_evt,
  input logic drop_evt,
  input logic push_evt,
  input logic pop_evt,
  input logic fifo_empty,
  input logic tx_phase
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag); // R7
  AST_DROP_RAISES_OVF: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> ovf_flag); // R7
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst)
    push_evt |=> !fifo_empty); // R7
  AST_MID_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (half_tick && !tx_phase) |=> (ser_out != $past(ser_out))); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(ser_out)); // R5
  AST_SYNC_LEADS: assert property (@(posedge clk) disable iff (rst)
    pop_evt |=> ser_out); // R4
  AST_TRIG_VALID: assert property (@(posedge clk) disable iff (rst)
    trig_evt |-> smp_valid); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !ovf_flag); // R8
endmodule

bind spike_compressor spike_compressor_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .half_tick(half_tick),
  .ser_out(ser_out), .ovf_flag(ovf_flag), .trig_evt(trig_evt),
  .drop_evt(drop_evt), .push_evt(push_evt), .pop_evt(pop_evt),
  .fifo_empty(fifo_empty), .tx_phase(tx_phase)
);

// File: tb/sim_spike_compressor.sv
module sim_spike_compressor;
  logic         clk = 0;
  logic         rst = 1;
  logic         smp_valid = 0;
  logic [5:0]   smp_chan = 0;
  logic [7:0]   smp_data = 0;
  logic [511:0] thr_vec = '1;
  logic         half_tick = 1;
  logic         ser_out, ovf_flag;

  spike_compressor u0 (.clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .thr_vec(thr_vec), .half_tick(half_tick),
    .ser_out(ser_out), .ovf_flag(ovf_flag));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- line decoder ----------------
  int halfcnt = 0, bitn = 0, in_fr = 0, fpos = 0;
  int rx_cnt = 0, stray = 0, viol = 0;
  logic       h0 = 0;
  logic [7:0] sh = 0;
  logic [7:0] fbuf [0:21];
  logic [7:0] rx_ch [0:63];
  logic [7:0] rx_dat [0:63][0:19];

  always @(negedge clk) begin
    if (rst) begin
      halfcnt = 0; bitn = 0; in_fr = 0; fpos = 0;
    end else if (halfcnt == 0) begin
      h0 = ser_out; halfcnt = 1;
    end else begin
      halfcnt = 0;
      if (ser_out == h0) viol++;
      sh = {sh[6:0], h0};
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (in_fr == 0) begin
          if (sh == 8'hA5) begin in_fr = 1; fpos = 1; end
          else if (sh != 8'h00) stray++;
        end else begin
          fbuf[fpos] = sh; fpos++;
          if (fpos == 22) begin
            if (rx_cnt < 64) begin
              rx_ch[rx_cnt] = fbuf[1];
              for (int k = 0; k < 20; k++) rx_dat[rx_cnt][k] = fbuf[k+2];
              rx_cnt++;
            end
            in_fr = 0;
          end
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] trace [0:47];
  int tlen = 0;
  logic [7:0] exp_dat [0:3][0:19];
  int nexp = 0;

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic send_round(input int tch, input logic [7:0] v, input bit all);
    for (int c = 0; c < 64; c++) begin
      if (c % 16 == 7) begin   // invalid bubble with a value that would cross
        smp_valid = 0; smp_chan = 6'(tch); smp_data = 8'hFF; tick();
      end
      smp_valid = 1; smp_chan = 6'(c);
      smp_data = (all || c == tch) ? v : 8'h00;
      tick();
    end
    smp_valid = 0;
  endtask

  // bench view of detection and windowing
  task automatic build_expected(input logic [7:0] thr);
    bit busy = 0; int st = 0, cnt = 0; logic [7:0] prev = 0;
    nexp = 0;
    for (int r = 0; r < tlen; r++) begin
      if (!busy && prev <= thr && trace[r] > thr) begin busy = 1; st = r; cnt = 1; end
      else if (busy) cnt++;
      if (busy && cnt == 16) begin
        for (int k = 0; k < 20; k++)
          exp_dat[nexp][k] = (st - 4 + k < 0) ? 8'h00 : trace[st - 4 + k];
        nexp++; busy = 0;
      end
      prev = trace[r];
    end
  endtask

  task automatic run_case(input int ch, input logic [7:0] thr, input string req);
    int base;
    thr_vec = '1;
    thr_vec[ch*8 +: 8] = thr;
    build_expected(thr);
    base = rx_cnt;
    for (int r = 0; r < tlen; r++) send_round(ch, trace[r], 0);
    for (int r = 0; r < 6; r++) send_round(ch, 8'h00, 0);
    repeat ((nexp + 1) * 400) tick();
    check(rx_cnt - base == nexp, req, $sformatf("frame count ch%0d", ch), rx_cnt - base, nexp);
    for (int f = 0; f < nexp && base + f < rx_cnt; f++) begin
      int bad = -1;
      check(rx_ch[base+f] == 8'(ch), "R4", "channel byte", rx_ch[base+f], ch);
      for (int k = 0; k < 20; k++)
        if (bad < 0 && rx_dat[base+f][k] != exp_dat[f][k]) bad = k;
      check(bad < 0, "R2 R9", $sformatf("window ch%0d frame%0d idx%0d", ch, f, bad),
            bad < 0 ? 0 : rx_dat[base+f][bad], bad < 0 ? 0 : exp_dat[f][bad]);
    end
  endtask

  // vector table: {channel, threshold, base level}
  localparam logic [21:0] VEC [4] = '{
    {6'd0,  8'h40, 8'h10},
    {6'd63, 8'h7F, 8'h7A},   // sample equal to threshold must not trigger
    {6'd17, 8'hC0, 8'h00},
    {6'd42, 8'h05, 8'h00}
  };

  initial begin
    #1500000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    @(negedge clk);
    check(ovf_flag == 0, "R8", "ovf after reset", ovf_flag, 0);
    check(ser_out == 0, "R8", "first half after reset", ser_out, 0);
    tick(); rst = 0;
    repeat (400) tick();
    check(rx_cnt == 0, "R6", "frames while idle", rx_cnt, 0);
    check(stray == 0, "R6", "non-idle bytes while idle", stray, 0);

    for (int v = 0; v < 4; v++) begin
      logic [7:0] thr, bs;
      thr = VEC[v][15:8]; bs = VEC[v][7:0];
      tlen = 24;
      for (int r = 0; r < 24; r++)
        trace[r] = (r < 6) ? bs + 8'(r) : (r < 22) ? thr + 8'(r) : 8'h00;
      run_case(int'(VEC[v][21:16]), thr, "R1");
    end

    // R3: oscillating channel, crossings during a window are ignored
    tlen = 33;
    for (int r = 0; r < 33; r++) trace[r] = (r % 2 == 1) ? 8'h60 : 8'h10;
    run_case(9, 8'h50, "R3");
    check(nexp == 2, "R3", "bench expects two windows", nexp, 2);

    // R8: reset during capture clears history and capture state
    thr_vec = '1; thr_vec[3*8 +: 8] = 8'h30;
    for (int r = 0; r < 5; r++) send_round(3, 8'h40, 0);
    rst = 1; repeat (3) tick(); rst = 0;
    tlen = 20;
    for (int r = 0; r < 20; r++) trace[r] = (r < 3) ? 8'h40 : 8'h20;
    run_case(3, 8'h30, "R8");

    // R7: every channel completes at once, FIFO overflows
    begin
      int base;
      base = rx_cnt;
      thr_vec = '0;
      for (int r = 0; r < 20; r++) send_round(0, 8'h80, 1);
      for (int r = 0; r < 6; r++) send_round(0, 8'h00, 1);
      check(ovf_flag == 1, "R7", "overflow raised", ovf_flag, 1);
      repeat (6000) tick();
      check(rx_cnt - base >= 9 && rx_cnt - base <= 16, "R7", "frames kept",
            rx_cnt - base, 9);
      check(rx_ch[base] == 8'd0 && rx_dat[base][3] == 8'h00 && rx_dat[base][4] == 8'h80,
            "R7", "first kept frame", rx_ch[base], 0);
      check(ovf_flag == 1, "R7", "overflow sticky", ovf_flag, 1);
      rst = 1; repeat (2) tick(); rst = 0;
      @(negedge clk);
      check(ovf_flag == 0, "R8", "overflow cleared", ovf_flag, 0);
      repeat (400) tick();
    end

    check(viol == 0, "R5", "Manchester halves equal", viol, 0);
    check(stray == 0, "R6", "non-idle bytes between frames", stray, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule